// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs one transfer at a time between an internal requester and an external parallel memory bus. The requester presents a word address, a direction and, for writes, a data word. The block matches the address against four programmable windows and raises the select line for the matching window. It then drives the external address, the data and the read or write strobe. When the request is done, it pulses ready and, for reads, presents the assembled word.

Timing runs on an I/O clock. The I/O clock is an enable derived from the peripheral clock by a selectable ratio. Each external bus cycle has three phases: address setup, strobe and hold. The strobe phase is stretched by a wait count and/or an acknowledge input. Reads and writes have their own wait counts. A 16-bit or 24-bit word can be split across several bus cycles on an 8-bit or 16-bit bus, and the external address advances for each part.

All `cfg_*` inputs are static configuration and must not change while a transfer is in progress.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: A request address A selects window i when base_i <= A < base_i + size_i. When several windows match, the lowest index wins. The one-hot `ext_bank_sel` is held for the whole transfer and is zero when idle.
- R2: An address outside every window raises no select and no strobe. `req_ready` is high in the clock right after the request clock, and `req_rdata` is zero.
- R3: `cfg_io_div` values 0, 1, 2, 3 and 4 give one I/O clock every 1, 2, 4, 16 and 32 peripheral clocks. Values 5 to 7 behave as 32.
- R4: Each bus cycle has three phases. Address setup lasts one I/O clock. The strobe lasts W+1 I/O clocks in count mode, where W is the wait count. Hold lasts one I/O clock. With B parts and ratio D, `req_ready` is high exactly B*(W+3)*D+1 clocks after the request clock, counting the request clock as 1.
- R5: Read strobes use `cfg_rd_wait` as W and write strobes use `cfg_wr_wait`.
- R6: `cfg_done_mode` selects how the strobe phase ends, with `ext_ack` sampled on I/O clock edges:
  - 0 ends on the count alone.
  - 1 ends on acknowledge alone.
  - 2 needs both the count and acknowledge.
  - 3 needs either the count or acknowledge.
- R7: A polarity bit of 1 makes its strobe active high, and 0 makes it active low. When no transfer is running, both strobes sit at their inactive level.
- R8: The number of parts B is 1 for a 16-bit word on a 16-bit bus, 2 for a 24-bit word on a 16-bit bus, 2 for a 16-bit word on an 8-bit bus, and 3 for a 24-bit word on an 8-bit bus. On a 16-bit bus, the first part of a 24-bit word carries bits 15:0 and the second carries bits 23:16 on data bits 7:0. On an 8-bit bus, the parts go least significant byte first on data bits 7:0. Unused data bits are driven zero. The external address of part k is A*B+k.
- R9: Read data is captured on the I/O edge that ends each strobe phase and placed in the same lanes as the write parts. For 16-bit words, `req_rdata[23:16]` is zero.
- R10: `req_ready` is a single-clock pulse.
- R11: `ext_dout_en` is high only during a write transfer to a matched window. It is never high while the read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_base | input | NBANK*AW | Window base addresses, window i at bits i*AW |
| cfg_bank_size | input | NBANK*AW | Window sizes in words, window i at bits i*AW |
| cfg_rd_wait | input | WW | Read wait count |
| cfg_wr_wait | input | WW | Write wait count |
| cfg_done_mode | input | 2 | Strobe completion mode |
| cfg_io_div | input | 3 | I/O clock ratio select |
| cfg_rd_pol | input | 1 | Read strobe active level |
| cfg_wr_pol | input | 1 | Write strobe active level |
| cfg_bus8 | input | 1 | 1: 8-bit external bus, 0: 16-bit |
| cfg_word24 | input | 1 | 1: 24-bit words, 0: 16-bit words |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Word address |
| req_wdata | input | WORD_W | Write word |
| req_ready | output | 1 | Completion pulse |
| req_rdata | output | WORD_W | Assembled read word |
| ext_addr | output | AW+2 | External bus address |
| ext_bank_sel | output | NBANK | One-hot window selects |
| ext_rd_strb | output | 1 | Read strobe |
| ext_wr_strb | output | 1 | Write strobe |
| ext_dout | output | BUS_W | Write data |
| ext_dout_en | output | 1 | Write data drive enable |
| ext_din | input | BUS_W | Read data |
| ext_ack | input | 1 | External acknowledge |

## Verification
A wrong phase state or a wrong divider count shows as a wrong ready latency, so the bench counts that latency to the exact clock on every transfer. A stuck wait counter is caught by the measured length of each strobe, which exposes it within one bus cycle.

A wrong part counter, or a wrong address offset, would scramble data across external locations. This shows up when a write is read back as a different word, and in the raw contents written at each external address.

A bad window decode shows as an unexpected select during the transfer. For an unmapped address it shows as a ready that comes too late.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } xb_state_e;

  typedef enum logic [1:0] {
    DM_COUNT  = 2'd0,
    DM_ACK    = 2'd1,
    DM_BOTH   = 2'd2,
    DM_EITHER = 2'd3
  } xb_done_e;

  // peripheral clocks per I/O clock
  function automatic logic [5:0] io_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    io_ratio = 6'd1;
      3'd1:    io_ratio = 6'd2;
      3'd2:    io_ratio = 6'd4;
      3'd3:    io_ratio = 6'd16;
      default: io_ratio = 6'd32;
    endcase
  endfunction

  // bus cycles needed for one word
  function automatic logic [1:0] part_count(input logic bus8, input logic word24);
    if (bus8) part_count = word24 ? 2'd3 : 2'd2;
    else      part_count = word24 ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/xbus_io_tick.sv
module xbus_io_tick #(
  parameter int CW = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] div_sel,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'(xbus_pkg::io_ratio(div_sel)) - CW'(1);
  assign tick = run && (cnt == lim);

  // counter restarts whenever the sequencer is idle so phases are whole I/O clocks
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/xbus_bank_dec.sv
module xbus_bank_dec #(
  parameter int AW    = 16,
  parameter int NBANK = 4
) (
  input  logic [AW-1:0]       addr,
  input  logic [NBANK*AW-1:0] base_flat,
  input  logic [NBANK*AW-1:0] size_flat,
  output logic [NBANK-1:0]    sel,
  output logic                hit
);
  logic [NBANK-1:0] in_rng;

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_win
      logic [AW-1:0] b, s, off;
      assign b   = base_flat[g*AW +: AW];
      assign s   = size_flat[g*AW +: AW];
      assign off = addr - b;
      assign in_rng[g] = (addr >= b) && (off < s);
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end

  assign hit = |in_rng;
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic [1:0]        part,
  input  logic              bus8,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic [WORD_W-1:0] rdata
);
  localparam int BY   = 8;
  localparam int HI_W = WORD_W - BUS_W;

  always_comb begin
    dout = '0;
    if (bus8) begin
      case (part)
        2'd0:    dout[BY-1:0] = wdata[BY-1:0];
        2'd1:    dout[BY-1:0] = wdata[2*BY-1:BY];
        default: dout[BY-1:0] = wdata[3*BY-1:2*BY];
      endcase
    end else if (part == 2'd0) begin
      dout = wdata[BUS_W-1:0];
    end else begin
      dout[HI_W-1:0] = wdata[WORD_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rdata <= '0;
    end else if (capture) begin
      if (bus8) begin
        case (part)
          2'd0:    rdata[BY-1:0]      <= din[BY-1:0];
          2'd1:    rdata[2*BY-1:BY]   <= din[BY-1:0];
          default: rdata[3*BY-1:2*BY] <= din[BY-1:0];
        endcase
      end else if (part == 2'd0) begin
        rdata[BUS_W-1:0] <= din;
      end else begin
        rdata[WORD_W-1:BUS_W] <= din[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
  parameter int AW     = 16,
  parameter int NBANK  = 4,
  parameter int WW     = 4,
  parameter int BUS_W  = 16,
  parameter int WORD_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBANK*AW-1:0] cfg_bank_base,
  input  logic [NBANK*AW-1:0] cfg_bank_size,
  input  logic [WW-1:0]       cfg_rd_wait,
  input  logic [WW-1:0]       cfg_wr_wait,
  input  logic [1:0]          cfg_done_mode,
  input  logic [2:0]          cfg_io_div,
  input  logic                cfg_rd_pol,
  input  logic                cfg_wr_pol,
  input  logic                cfg_bus8,
  input  logic                cfg_word24,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic [WORD_W-1:0]   req_rdata,
  output logic [AW+1:0]       ext_addr,
  output logic [NBANK-1:0]    ext_bank_sel,
  output logic                ext_rd_strb,
  output logic                ext_wr_strb,
  output logic [BUS_W-1:0]    ext_dout,
  output logic                ext_dout_en,
  input  logic [BUS_W-1:0]    ext_din,
  input  logic                ext_ack
);
  import xbus_pkg::*;

  localparam int EAW = AW + 2;

  xb_state_e         state;
  logic              is_wr;
  logic [1:0]        part, last_part;
  logic [WW-1:0]     wcnt;
  logic [WORD_W-1:0] wdata_q;
  logic [NBANK-1:0]  sel_q;
  logic [EAW-1:0]    addr_q;
  logic              strb_q;
  logic              ready_q;

  logic              tick;
  logic [NBANK-1:0]  dec_sel;
  logic              dec_hit;
  logic              accept;
  logic [WW-1:0]     wait_lim;
  logic              cnt_done;
  logic              end_now;
  logic              capture;
  logic [1:0]        parts;

  xbus_io_tick #(.CW(6)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (state != ST_IDLE),
    .div_sel (cfg_io_div),
    .tick    (tick)
  );

  xbus_bank_dec #(.AW(AW), .NBANK(NBANK)) u_dec (
    .addr      (req_addr),
    .base_flat (cfg_bank_base),
    .size_flat (cfg_bank_size),
    .sel       (dec_sel),
    .hit       (dec_hit)
  );

  xbus_lane #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_lane (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .capture (capture),
    .part    (part),
    .bus8    (cfg_bus8),
    .wdata   (wdata_q),
    .din     (ext_din),
    .dout    (ext_dout),
    .rdata   (req_rdata)
  );

  assign parts    = part_count(cfg_bus8, cfg_word24);
  assign accept   = (state == ST_IDLE) && req_valid;
  assign wait_lim = is_wr ? cfg_wr_wait : cfg_rd_wait;
  assign cnt_done = (wcnt >= wait_lim);

  always_comb begin
    case (xb_done_e'(cfg_done_mode))
      DM_COUNT: end_now = cnt_done;
      DM_ACK:   end_now = ext_ack;
      DM_BOTH:  end_now = cnt_done && ext_ack;
      default:  end_now = cnt_done || ext_ack;
    endcase
  end

  assign capture = (state == ST_STRB) && tick && end_now && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      part      <= '0;
      last_part <= '0;
      wcnt      <= '0;
      wdata_q   <= '0;
      sel_q     <= '0;
      addr_q    <= '0;
      strb_q    <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (dec_hit) begin
              state     <= ST_SETUP;
              is_wr     <= req_write;
              wdata_q   <= req_wdata;
              sel_q     <= dec_sel;
              part      <= '0;
              last_part <= parts - 2'd1;
              addr_q    <= EAW'(req_addr) * EAW'(parts);
            end else begin
              ready_q <= 1'b1;
            end
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state  <= ST_STRB;
            strb_q <= 1'b1;
            wcnt   <= '0;
          end
        end
        ST_STRB: begin
          if (tick) begin
            if (end_now) begin
              state  <= ST_HOLD;
              strb_q <= 1'b0;
            end else if (wcnt != {WW{1'b1}}) begin
              wcnt <= wcnt + WW'(1);
            end
          end
        end
        default: begin
          if (tick) begin
            if (part == last_part) begin
              state   <= ST_IDLE;
              sel_q   <= '0;
              is_wr   <= 1'b0;
              ready_q <= 1'b1;
            end else begin
              state  <= ST_SETUP;
              part   <= part + 2'd1;
              addr_q <= addr_q + EAW'(1);
            end
          end
        end
      endcase
    end
  end

  assign req_ready    = ready_q;
  assign ext_addr     = addr_q;
  assign ext_bank_sel = sel_q;
  assign ext_rd_strb  = (strb_q && !is_wr) ? cfg_rd_pol : !cfg_rd_pol;
  assign ext_wr_strb  = (strb_q &&  is_wr) ? cfg_wr_pol : !cfg_wr_pol;
  assign ext_dout_en  = is_wr && (state != ST_IDLE);
endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_rd_pol,
  input logic             cfg_wr_pol,
  input logic [1:0]       cfg_done_mode,
  input logic             ext_rd_strb,
  input logic             ext_wr_strb,
  input logic [NBANK-1:0] ext_bank_sel,
  input logic             ext_ack,
  input logic             ext_dout_en,
  input logic             req_ready
);
  logic rd_on, wr_on;
  assign rd_on = (ext_rd_strb == cfg_rd_pol);
  assign wr_on = (ext_wr_strb == cfg_wr_pol);

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ext_bank_sel));

  a_r1_sel_held: assert property (@(posedge clk) disable iff (rst)
    (ext_bank_sel != '0 && $past(ext_bank_sel) != '0) |-> ext_bank_sel == $past(ext_bank_sel));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_on && wr_on));

  a_r2_strobe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (rd_on || wr_on) |-> (ext_bank_sel != '0));

  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    ext_dout_en |-> !rd_on);

  a_r6_ack_ends_read: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_on) && cfg_done_mode == 2'd1) |-> $past(ext_ack));

  a_r6_ack_ends_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_on) && cfg_done_mode == 2'd1) |-> $past(ext_ack));
endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_rd_pol    (cfg_rd_pol),
  .cfg_wr_pol    (cfg_wr_pol),
  .cfg_done_mode (cfg_done_mode),
  .ext_rd_strb   (ext_rd_strb),
  .ext_wr_strb   (ext_wr_strb),
  .ext_bank_sel  (ext_bank_sel),
  .ext_ack       (ext_ack),
  .ext_dout_en   (ext_dout_en),
  .req_ready     (req_ready)
);

// File: tb/xbus_wait_ctrl_tb_top.sv
module xbus_wait_ctrl_tb_top;
  localparam int AW = 16, NBANK = 4, WW = 4, BUS_W = 16, WORD_W = 24;

  typedef struct packed {
    logic [2:0]  div;
    logic        bus8;
    logic        w24;
    logic [3:0]  rdw;
    logic [3:0]  wrw;
    logic        pol;
    logic [15:0] addr;
    logic [23:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 1'b0, 1'b0, 4'd1, 4'd0, 1'b1, 16'h0010, 24'h77BEEF},
    '{3'd1, 1'b0, 1'b1, 4'd2, 4'd1, 1'b0, 16'h0120, 24'hA1B2C3},
    '{3'd2, 1'b1, 1'b0, 4'd0, 4'd3, 1'b1, 16'h1004, 24'h5A5A33},
    '{3'd3, 1'b1, 1'b1, 4'd1, 4'd0, 1'b0, 16'h2010, 24'h123456},
    '{3'd4, 1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 16'h0350, 24'hFEDCBA},
    '{3'd7, 1'b1, 1'b1, 4'd0, 4'd1, 1'b1, 16'h20FF, 24'h0F1E2D}
  };

  localparam logic [15:0] BB [4] = '{16'h0000, 16'h0100, 16'h1000, 16'h2000};
  localparam logic [15:0] BS [4] = '{16'h0200, 16'h0300, 16'h0010, 16'h0400};

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NBANK*AW-1:0] cfg_bank_base, cfg_bank_size;
  logic [WW-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
  logic [1:0] cfg_done_mode = 2'd0;
  logic [2:0] cfg_io_div = 3'd0;
  logic cfg_rd_pol = 1'b1, cfg_wr_pol = 1'b1, cfg_bus8 = 1'b0, cfg_word24 = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready;
  logic [WORD_W-1:0] req_rdata;
  logic [AW+1:0] ext_addr;
  logic [NBANK-1:0] ext_bank_sel;
  logic ext_rd_strb, ext_wr_strb, ext_dout_en;
  logic [BUS_W-1:0] ext_dout, ext_din;
  logic ext_ack = 1'b0;

  assign cfg_bank_base = {BB[3], BB[2], BB[1], BB[0]};
  assign cfg_bank_size = {BS[3], BS[2], BS[1], BS[0]};

  xbus_wait_ctrl #(.AW(AW), .NBANK(NBANK), .WW(WW), .BUS_W(BUS_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_bank_base(cfg_bank_base), .cfg_bank_size(cfg_bank_size),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait), .cfg_done_mode(cfg_done_mode),
    .cfg_io_div(cfg_io_div), .cfg_rd_pol(cfg_rd_pol), .cfg_wr_pol(cfg_wr_pol),
    .cfg_bus8(cfg_bus8), .cfg_word24(cfg_word24), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .ext_addr(ext_addr),
    .ext_bank_sel(ext_bank_sel), .ext_rd_strb(ext_rd_strb), .ext_wr_strb(ext_wr_strb),
    .ext_dout(ext_dout), .ext_dout_en(ext_dout_en), .ext_din(ext_din), .ext_ack(ext_ack)
  );

  // external memory model
  logic [15:0] mem [0:1023];
  initial for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
  assign ext_din = mem[ext_addr[9:0]];
  always @(posedge clk) if (ext_wr_strb == cfg_wr_pol) mem[ext_addr[9:0]] <= ext_dout;

  // strobe length and select monitors
  int rd_run = 0, wr_run = 0, last_rd = 0, last_wr = 0;
  logic [NBANK-1:0] sel_seen = '0;
  always @(negedge clk) begin
    sel_seen <= sel_seen | ext_bank_sel;
    if (ext_rd_strb == cfg_rd_pol) rd_run <= rd_run + 1;
    else if (rd_run != 0) begin last_rd <= rd_run; rd_run <= 0; end
    if (ext_wr_strb == cfg_wr_pol) wr_run <= wr_run + 1;
    else if (wr_run != 0) begin last_wr <= wr_run; wr_run <= 0; end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] s);
    case (s) 3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd3: return 16; default: return 32; endcase
  endfunction

  function automatic int parts_of(input logic b8, input logic w24);
    return b8 ? (w24 ? 3 : 2) : (w24 ? 2 : 1);
  endfunction

  function automatic logic [3:0] exp_sel(input logic [15:0] a);
    for (int i = 0; i < 4; i++) if (a >= BB[i] && (a - BB[i]) < BS[i]) return 4'(1 << i);
    return 4'd0;
  endfunction

  // issue one request, return clocks to ready (request clock counts as 1)
  task automatic do_req(input logic wr, input logic [15:0] a, input logic [23:0] d,
                        output int lat, output logic [23:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    sel_seen = '0;
    lat = 0;
    @(posedge clk); lat++;
    @(negedge clk); req_valid = 1'b0;
    while (!req_ready && lat < 5000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rd = req_rdata;
    @(negedge clk);
    chk("R10 ready single pulse", 32'(req_ready), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [23:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R10 ready low after reset", 32'(req_ready), 32'd0);
    chk("R1 no select after reset", 32'(ext_bank_sel), 32'd0);
    chk("R7 idle read strobe level", 32'(ext_rd_strb), 32'd0);
    chk("R11 no drive after reset", 32'(ext_dout_en), 32'd0);

    // table walk: write then read back each vector in count mode
    foreach (VECS[k]) begin
      vec_t v;
      int dd, bb;
      logic [23:0] expw;
      v = VECS[k];
      cfg_io_div = v.div; cfg_bus8 = v.bus8; cfg_word24 = v.w24;
      cfg_rd_wait = v.rdw; cfg_wr_wait = v.wrw; cfg_rd_pol = v.pol; cfg_wr_pol = !v.pol;
      cfg_done_mode = 2'd0; ext_ack = 1'b0;
      dd = ratio_of(v.div); bb = parts_of(v.bus8, v.w24);
      expw = v.w24 ? v.data : {8'h0, v.data[15:0]};
      @(negedge clk);
      chk("R7 idle write strobe level", 32'(ext_wr_strb), 32'(v.pol));
      do_req(1'b1, v.addr, v.data, lat, rd);
      chk("R4 R5 R3 write latency", 32'(lat), 32'(bb * (int'(v.wrw) + 3) * dd + 1));
      chk("R5 write strobe length", 32'(last_wr), 32'((int'(v.wrw) + 1) * dd));
      chk("R1 write select", 32'(sel_seen), 32'(exp_sel(v.addr)));
      do_req(1'b0, v.addr, 24'h0, lat, rd);
      chk("R4 R5 R3 read latency", 32'(lat), 32'(bb * (int'(v.rdw) + 3) * dd + 1));
      chk("R5 read strobe length", 32'(last_rd), 32'((int'(v.rdw) + 1) * dd));
      chk("R1 read select", 32'(sel_seen), 32'(exp_sel(v.addr)));
      chk("R8 R9 read back word", 32'(rd), 32'(expw));
    end

    // unmapped and window edges
    cfg_io_div = 3'd0; cfg_bus8 = 1'b0; cfg_word24 = 1'b1; cfg_rd_wait = 4'd0;
    cfg_rd_pol = 1'b1; cfg_wr_pol = 1'b1;
    do_req(1'b0, 16'h3000, 24'h0, lat, rd);
    chk("R2 unmapped latency", 32'(lat), 32'd1);
    chk("R2 unmapped data zero", 32'(rd), 32'd0);
    chk("R2 unmapped no select", 32'(sel_seen), 32'd0);
    do_req(1'b1, 16'h1010, 24'h111111, lat, rd);
    chk("R2 R1 one past window end", 32'(lat), 32'd1);
    do_req(1'b0, 16'h100F, 24'h0, lat, rd);
    chk("R1 last word of window", 32'(sel_seen), 32'b0100);

    // raw packing order on the bus
    cfg_bus8 = 1'b1; cfg_word24 = 1'b1;
    do_req(1'b1, 16'h0002, 24'hC3B2A1, lat, rd);
    chk("R8 byte part 0 at 3A", 32'(mem[6]), 32'h00A1);
    chk("R8 byte part 1 at 3A+1", 32'(mem[7]), 32'h00B2);
    chk("R8 byte part 2 at 3A+2", 32'(mem[8]), 32'h00C3);
    cfg_bus8 = 1'b0;
    do_req(1'b1, 16'h0004, 24'h778899, lat, rd);
    chk("R8 low half at 2A", 32'(mem[8]), 32'h8899);
    chk("R8 high byte at 2A+1", 32'(mem[9]), 32'h0077);

    // completion modes
    cfg_io_div = 3'd1; cfg_rd_wait = 4'd5; ext_ack = 1'b1;
    cfg_done_mode = 2'd1;
    do_req(1'b0, 16'h0004, 24'h0, lat, rd);
    chk("R6 ack-only ends at first I/O edge", 32'(last_rd), 32'd2);
    cfg_done_mode = 2'd3;
    do_req(1'b0, 16'h0004, 24'h0, lat, rd);
    chk("R6 count-or-ack ends early", 32'(last_rd), 32'd2);
    cfg_rd_wait = 4'd2; cfg_done_mode = 2'd2;
    do_req(1'b0, 16'h0004, 24'h0, lat, rd);
    chk("R6 count-and-ack waits for count", 32'(last_rd), 32'd6);
    chk("R9 read word via ack modes", 32'(rd), 32'h778899);

    // ack-only with acknowledge held low stalls the strobe
    cfg_done_mode = 2'd1; ext_ack = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0004;
    @(negedge clk); req_valid = 1'b0;
    begin
      int seen = 0;
      repeat (40) begin @(negedge clk); if (req_ready) seen = 1; end
      chk("R6 strobe held without ack", 32'(ext_rd_strb), 32'd1);
      chk("R6 no ready without ack", 32'(seen), 32'd0);
      ext_ack = 1'b1;
      seen = 0;
      repeat (30) begin @(negedge clk); if (req_ready) seen = 1; end
      chk("R6 ack releases transfer", 32'(seen), 32'd1);
      chk("R9 stalled read data", 32'(req_rdata), 32'h778899);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule